// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block brings a DDR SDRAM from power-on to an operable state. After its asynchronous reset is released it raises the clock-enable line. It then walks a fixed list of seven commands on the command and address buses:

1. Precharge of all banks.
2. An extended mode register write that keeps the DLL enabled.
3. A mode register write that also resets the DLL.
4. A second precharge of all banks.
5. Two auto-refresh commands.
6. A closing mode register write with the DLL reset bit cleared.

Between any two of these commands the bus carries NOP.

The spacing after precharge and mode register writes comes from one runtime cycle count. The spacing after each refresh comes from a second count. Both are floored at two cycles. A third count sets how long the DLL needs to lock after its reset. The ready flag rises only after the last command's spacing has passed and the DLL wait has expired. Once high, the flag stays high until the next reset. The memory controller uses the flag to release normal traffic, so no read can reach the device before the DLL has locked.

Top module: `ddr_init_seq`

## Requirements
- R1: While rst_ni is low, cke_o is 0, the command is NOP (cs_n,ras_n,cas_n,we_n = 0,1,1,1), ba_o and addr_o are 0, and done_o is 0.
- R2: cke_o rises in the first cycle after reset release and then stays high. The first command, precharge-all (0,0,1,0 with addr_o bit 10 = 1 and ba_o = 0), appears in the cycle that follows.
- R3: Exactly seven commands are issued, in this order: precharge-all, extended mode write, mode write with DLL reset, precharge-all, refresh (0,0,0,1 with ba_o = 0 and addr_o = 0), refresh, mode write with DLL reset cleared.
- R4: The extended mode write uses code 0,0,0,0 with ba_o = 2'b01. Its addr_o equals ext_mode_i with bit 0 forced to 0, which keeps the DLL enabled.
- R5: Both mode writes use code 0,0,0,0 with ba_o = 2'b00. Their addr_o equals mode_i with bit 8 forced to 1 for the first write and forced to 0 for the closing write.
- R6: The cycle distance from a precharge-all or mode register write to the next command is max(t_gap_i, 2).
- R7: The cycle distance from each refresh to the next command is max(t_rfc_i, 2).
- R8: Every cycle between commands carries NOP, and no two commands are adjacent.
- R9: done_o first rises in cycle max(T7 + max(t_gap_i,2), T3 + t_dll_i). Here T3 is the issue cycle of the DLL-reset mode write and T7 is the issue cycle of the closing mode write. While done_o is high, the bus carries NOP with cke_o high.
- R10: Once high, done_o stays high until reset.
- R11: A reset in mid-sequence returns the block at once to the R1 state, and the whole sequence restarts after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | AW | Operating mode register value (bit 8 overridden) |
| ext_mode_i | input | AW | Extended mode register value (bit 0 overridden) |
| t_gap_i | input | CW | Cycles after precharge or mode write (floor 2) |
| t_rfc_i | input | CW | Cycles after each refresh (floor 2) |
| t_dll_i | input | CW | Cycles from DLL reset until ready is allowed |
| cke_o | output | 1 | Clock enable to the memory |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address |
| addr_o | output | AW | Address bus |
| done_o | output | 1 | Initialization complete, sticky |

## Verification
The end of the spacing after the closing mode write and the expiry of the DLL lock wait are two independent events, and both gate the ready flag. They can land on the same cycle. The bench provokes this by choosing t_dll_i equal to 3*max(t_gap_i,2) + 2*max(t_rfc_i,2). That value makes the DLL wait expire exactly when the final spacing ends. The bench also runs one cycle past that point and far beyond it. In each case it judges the cycle in which done_o first rises against the maximum of the two deadlines, and it confirms that the flag then holds.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;
  typedef enum logic [2:0] {PH_PWR, PH_WAKE, PH_ISSUE, PH_GAP, PH_FIN} phase_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_t;

  localparam cmd_t CMD_NOP  = '{1'b0, 1'b1, 1'b1, 1'b1};
  localparam cmd_t CMD_PALL = '{1'b0, 1'b0, 1'b1, 1'b0};
  localparam cmd_t CMD_MRS  = '{1'b0, 1'b0, 1'b0, 1'b0};
  localparam cmd_t CMD_REF  = '{1'b0, 1'b0, 1'b0, 1'b1};

  localparam int STEP_W      = 3;
  localparam int STEP_LAST   = 6;
  localparam int STEP_DLLRST = 2;
  localparam int ALL_BANK_BIT = 10;
  localparam int DLL_RST_BIT  = 8;
  localparam int DLL_DIS_BIT  = 0;
endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ddr_init_cmd_gen.sv
module ddr_init_cmd_gen
  import ddr_init_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic              active_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [AW-1:0]     mode_i,
  input  logic [AW-1:0]     ext_mode_i,
  output cmd_t              cmd_o,
  output logic [1:0]        ba_o,
  output logic [AW-1:0]     addr_o
);
  localparam logic [AW-1:0] ALL_BANK = AW'(1) << ALL_BANK_BIT;
  localparam logic [AW-1:0] DLL_RST  = AW'(1) << DLL_RST_BIT;
  localparam logic [AW-1:0] DLL_DIS  = AW'(1) << DLL_DIS_BIT;

  always_comb begin
    cmd_o  = CMD_NOP;
    ba_o   = 2'b00;
    addr_o = '0;
    if (active_i) begin
      case (step_i)
        3'd0, 3'd3: begin
          cmd_o  = CMD_PALL;
          addr_o = ALL_BANK;
        end
        3'd1: begin
          cmd_o  = CMD_MRS;
          ba_o   = 2'b01;
          addr_o = ext_mode_i & ~DLL_DIS;
        end
        3'd2: begin
          cmd_o  = CMD_MRS;
          addr_o = mode_i | DLL_RST;
        end
        3'd4, 3'd5: cmd_o = CMD_REF;
        3'd6: begin
          cmd_o  = CMD_MRS;
          addr_o = mode_i & ~DLL_RST;
        end
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int AW = 13,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] mode_i,
  input  logic [AW-1:0] ext_mode_i,
  input  logic [CW-1:0] t_gap_i,
  input  logic [CW-1:0] t_rfc_i,
  input  logic [CW-1:0] t_dll_i,
  output logic          cke_o,
  output logic          cs_n_o,
  output logic          ras_n_o,
  output logic          cas_n_o,
  output logic          we_n_o,
  output logic [1:0]    ba_o,
  output logic [AW-1:0] addr_o,
  output logic          done_o
);
  localparam logic [CW-1:0] MIN_GAP = CW'(2);

  phase_e            phase_q;
  logic [STEP_W-1:0] step_q;
  logic [CW-1:0]     gap_eff, rfc_eff, gap_sel, gap_cnt, dll_cnt;
  logic              issue, ref_step, gap_end;
  cmd_t              cmd;

  assign gap_eff  = (t_gap_i < MIN_GAP) ? MIN_GAP : t_gap_i;
  assign rfc_eff  = (t_rfc_i < MIN_GAP) ? MIN_GAP : t_rfc_i;
  assign ref_step = (step_q == STEP_W'(4)) || (step_q == STEP_W'(5));
  assign gap_sel  = ref_step ? rfc_eff : gap_eff;
  assign issue    = (phase_q == PH_ISSUE);
  assign gap_end  = (phase_q == PH_GAP) && (gap_cnt == CW'(1));

  // spacing after each command: loaded with span-1, next issue when it reads 1
  ddr_init_timer #(.W(CW)) u_gap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (issue),
    .val_i  (gap_sel - CW'(1)),
    .cnt_o  (gap_cnt)
  );

  // DLL lock wait, started by the DLL-reset mode write
  ddr_init_timer #(.W(CW)) u_dll (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (issue && (step_q == STEP_W'(STEP_DLLRST))),
    .val_i  (t_dll_i),
    .cnt_o  (dll_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_PWR;
      step_q  <= '0;
    end else begin
      case (phase_q)
        PH_PWR:   phase_q <= PH_WAKE;
        PH_WAKE:  phase_q <= PH_ISSUE;
        PH_ISSUE: phase_q <= PH_GAP;
        PH_GAP: if (gap_end) begin
          if (step_q == STEP_W'(STEP_LAST)) phase_q <= PH_FIN;
          else begin
            step_q  <= step_q + STEP_W'(1);
            phase_q <= PH_ISSUE;
          end
        end
        default:  phase_q <= PH_FIN;
      endcase
    end
  end

  ddr_init_cmd_gen #(.AW(AW)) u_cmd (
    .active_i   (issue),
    .step_i     (step_q),
    .mode_i     (mode_i),
    .ext_mode_i (ext_mode_i),
    .cmd_o      (cmd),
    .ba_o       (ba_o),
    .addr_o     (addr_o)
  );

  assign cke_o   = (phase_q != PH_PWR);
  assign cs_n_o  = cmd.cs_n;
  assign ras_n_o = cmd.ras_n;
  assign cas_n_o = cmd.cas_n;
  assign we_n_o  = cmd.we_n;
  assign done_o  = (phase_q == PH_FIN) && (dll_cnt <= CW'(1));
endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
  parameter int AW = 13
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cke_o,
  input logic          cs_n_o,
  input logic          ras_n_o,
  input logic          cas_n_o,
  input logic          we_n_o,
  input logic [1:0]    ba_o,
  input logic [AW-1:0] addr_o,
  input logic          done_o
);
  logic [3:0] code;
  logic nop, mrs, pall;
  assign code = {cs_n_o, ras_n_o, cas_n_o, we_n_o};
  assign nop  = (code == 4'b0111);
  assign mrs  = (code == 4'b0000);
  assign pall = (code == 4'b0010);

  // R1
  always @(posedge clk_i) if (!rst_ni)
    reset_quiet_chk: assert (!cke_o && nop && !done_o);

  // R2
  cke_first_pall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |=> (pall && addr_o[10]));

  // R2
  cke_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |=> cke_o);

  // R4
  ext_dll_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mrs && ba_o == 2'b01) |-> !addr_o[0]);

  // R5
  mrs_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrs |-> !ba_o[1]);

  // R8
  no_adjacent_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nop |=> nop);

  // R9
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (nop && cke_o));

  // R10
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
endmodule

bind ddr_init_seq ddr_init_seq_chk #(.AW(AW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cke_o   (cke_o),
  .cs_n_o  (cs_n_o),
  .ras_n_o (ras_n_o),
  .cas_n_o (cas_n_o),
  .we_n_o  (we_n_o),
  .ba_o    (ba_o),
  .addr_o  (addr_o),
  .done_o  (done_o)
);

// File: tb/ddr_init_seq_test.sv
`timescale 1ns/1ps
module ddr_init_seq_test;
  localparam int AW = 13;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] mode, ext_mode;
  logic [CW-1:0] t_gap, t_rfc, t_dll;
  logic cke, cs_n, ras_n, cas_n, we_n, done;
  logic [1:0] ba;
  logic [AW-1:0] addr;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  ddr_init_seq #(.AW(AW), .CW(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .ext_mode_i(ext_mode),
    .t_gap_i(t_gap), .t_rfc_i(t_rfc), .t_dll_i(t_dll),
    .cke_o(cke), .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .ba_o(ba), .addr_o(addr), .done_o(done)
  );

  // event log, sampled at the falling edge
  int cyc;
  int ev_n, done_t, cke_t, sticky_bad, cke_drop;
  int ev_t [16];
  logic [3:0] ev_c [16];
  logic [1:0] ev_b [16];
  logic [AW-1:0] ev_a [16];

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if ({cs_n, ras_n, cas_n, we_n} != 4'b0111) begin
      if (ev_n < 16) begin
        ev_t[ev_n] = cyc; ev_c[ev_n] = {cs_n, ras_n, cas_n, we_n};
        ev_b[ev_n] = ba;  ev_a[ev_n] = addr;
      end
      ev_n = ev_n + 1;
    end
    if (cke && cke_t < 0) cke_t = cyc;
    if (!cke && cke_t >= 0) cke_drop = cke_drop + 1;
    if (done && done_t < 0) done_t = cyc;
    if (!done && done_t >= 0) sticky_bad = sticky_bad + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_reset_state(input string req);
    check(cke == 1'b0, req, cke, 0);
    check({cs_n, ras_n, cas_n, we_n} == 4'b0111, req, {cs_n, ras_n, cas_n, we_n}, 7);
    check(ba == 2'b00 && addr == '0, req, addr, 0);
    check(done == 1'b0, req, done, 0);
  endtask

  task automatic run_seq(input int g, input int rf, input int dl,
                         input logic [AW-1:0] md, input logic [AW-1:0] em);
    int ge, re, ex_done, wait_n;
    int gaps [7];
    logic [3:0] ec [7];
    logic [1:0] eb [7];
    logic [AW-1:0] ea [7];
    @(posedge clk); #1;
    rst_n = 1'b0;
    t_gap = CW'(g); t_rfc = CW'(rf); t_dll = CW'(dl); mode = md; ext_mode = em;
    ev_n = 0; done_t = -1; cke_t = -1; sticky_bad = 0; cke_drop = 0;
    @(posedge clk); #1;
    check_reset_state("R1");
    rst_n = 1'b1;
    wait_n = 0;
    while (done_t < 0 && wait_n < 20000) begin
      @(posedge clk); wait_n = wait_n + 1;
    end
    repeat (25) @(posedge clk);
    #1;
    ge = (g < 2) ? 2 : g;
    re = (rf < 2) ? 2 : rf;
    ec = '{4'b0010, 4'b0000, 4'b0000, 4'b0010, 4'b0001, 4'b0001, 4'b0000};
    eb = '{2'b00, 2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00};
    ea = '{AW'(1) << 10, em & ~AW'(1), md | (AW'(1) << 8), AW'(1) << 10,
           AW'(0), AW'(0), md & ~(AW'(1) << 8)};
    gaps = '{ge, ge, ge, ge, re, re, ge};
    check(cke_t == 1, "R2 cke rise cycle", cke_t, 1);
    check(cke_drop == 0, "R2 cke held", cke_drop, 0);
    check(ev_n == 7, "R3/R8 command count", ev_n, 7);
    if (ev_n >= 7) begin
      check(ev_t[0] == 2, "R2 first command cycle", ev_t[0], 2);
      for (int i = 0; i < 7; i++) begin
        check(ev_c[i] == ec[i], $sformatf("R3 code step %0d", i), ev_c[i], ec[i]);
        check(ev_b[i] == eb[i], $sformatf("R4/R5 bank step %0d", i), ev_b[i], eb[i]);
        check(ev_a[i] == ea[i], $sformatf("R4/R5 addr step %0d", i), ev_a[i], ea[i]);
      end
      for (int i = 0; i < 6; i++)
        check(ev_t[i+1] - ev_t[i] == gaps[i],
              (i == 4 || i == 5) ? $sformatf("R7 spacing %0d", i) : $sformatf("R6 spacing %0d", i),
              ev_t[i+1] - ev_t[i], gaps[i]);
      ex_done = ev_t[6] + ge;
      if (ev_t[2] + dl > ex_done) ex_done = ev_t[2] + dl;
      check(done_t == ex_done, "R9 done cycle", done_t, ex_done);
    end
    check(sticky_bad == 0, "R10 done sticky", sticky_bad, 0);
    check(done == 1'b1, "R10 done still high", done, 1);
  endtask

  task automatic t_reset_state;
    @(posedge clk); #1;
    rst_n = 1'b0;
    @(posedge clk); #1;
    check_reset_state("R1 idle reset");
  endtask

  task automatic t_min_spacing;
    run_seq(0, 1, 0, 13'h0032, 13'h0003);
  endtask

  task automatic t_wide_spacing;
    run_seq(5, 23, 4, 13'h1f7f, 13'h1fff);
  endtask

  task automatic t_dll_dominates;
    run_seq(2, 3, 300, 13'h0100, 13'h0000);
  endtask

  task automatic t_coincide;
    run_seq(3, 7, 3 * 3 + 2 * 7, 13'h0062, 13'h0002);
    run_seq(3, 7, 3 * 3 + 2 * 7 + 1, 13'h0062, 13'h0002);
  endtask

  task automatic t_mid_reset;
    @(posedge clk); #1;
    rst_n = 1'b0;
    t_gap = 16'd4; t_rfc = 16'd6; t_dll = 16'd10; mode = 13'h0022; ext_mode = 13'h0;
    ev_n = 0; done_t = -1; cke_t = -1; sticky_bad = 0; cke_drop = 0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    while (ev_n < 3) @(posedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    check_reset_state("R11 mid-sequence reset");
    run_seq(4, 6, 10, 13'h0022, 13'h0);
  endtask

  initial begin
    #950000;
    total = total + 1;
    bad = bad + 1;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mode = '0; ext_mode = '0; t_gap = '0; t_rfc = '0; t_dll = '0;
    ev_n = 0; done_t = -1; cke_t = -1; sticky_bad = 0; cke_drop = 0;
    t_reset_state();
    t_min_spacing();
    t_wide_spacing();
    t_dll_dominates();
    t_coincide();
    t_mid_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule